// File: doc/BRIEF.md
# Picture Memory Map with Nametable Mirroring

This block sits between a picture processor and the storage it sees. It takes an access on a 16-bit address bus, keeps only the low 14 bits, and steers the access to one of three targets. The lowest 8 KB go out to the cartridge pattern port. The next region goes to a 2 KB nametable RAM held inside the block. The top 256 bytes reach a 32-entry palette held in registers.

The nametable region holds four logical 1 KB tables. A cartridge-supplied mode input folds them onto the two physical kilobytes. The palette folds the four upper-half backdrop entries onto their lower-half twins, for both reads and writes.

Reads are combinational from the addressed location. Writes to the internal RAM or the palette land on the rising clock edge. Cartridge writes are signalled on the port and stored outside the block.

Top module: `pic_mem_map`

## Requirements
- R1: Address bits 15:14 are ignored; an access behaves the same with them set or clear.
- R2: A masked address below 0x2000 drives cart_sel_o high while rd_i or wr_i is high. It drives cart_addr_o with the low 13 address bits and cart_we_o with wr_i, and rdata_o returns cart_rdata_i on a read.
- R3: A masked address from 0x2000 to 0x3EFF uses nametable offset (address − 0x2000) & 0xFFF, so 0x3000–0x3EFF alias 0x2000–0x2EFF.
- R4: Offset bits 11:10 name a logical table L and bits 9:0 a byte B. mirror_mode_i picks the physical table P: 0 gives P=L>>1, 1 gives P=L&1, 2 gives P=0, 3 gives P=1, and 4 or above gives P=L. nt_addr_o = ((P<<10)+B) & 0x7FF.
- R5: A nametable write stores wdata_i at nt_addr_o on the clock edge. A later read of the same physical address returns it combinationally.
- R6: A masked address from 0x3F00 up selects palette index I = (address − 0x3F00) & 0x1F. When I ≥ 0x10 and I[1:0] = 0, the index used is I − 0x10, and it appears on pal_idx_o.
- R7: Palette writes store at the folded index on the clock edge. Reads return the folded entry, and all 32 entries are zero after reset.
- R8: rdata_o is zero while rd_i is low. nt_we_o and pal_we_o are high only when wr_i is high in their region, so an access with wr_i low leaves stored data unchanged. At most one of cart_sel_o, nt_we_o and pal_we_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the palette |
| addr_i | input | 16 | Access address, upper two bits ignored |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| mirror_mode_i | input | 3 | Nametable folding mode from the cartridge |
| cart_rdata_i | input | 8 | Data returned by the cartridge pattern port |
| cart_sel_o | output | 1 | Cartridge port selected |
| cart_we_o | output | 1 | Cartridge write |
| cart_addr_o | output | 13 | Cartridge pattern address |
| rdata_o | output | 8 | Read data |
| nt_addr_o | output | 11 | Physical nametable RAM address |
| nt_we_o | output | 1 | Nametable RAM write enable |
| pal_idx_o | output | 5 | Folded palette index |
| pal_we_o | output | 1 | Palette write enable |

## Verification
The assertions take for granted that rd_i and wr_i are never high in the same cycle. They also assume the address and write data stay steady from one write into the read that follows it, so a read-after-write property compares like with like. The stimulus changes inputs only on the falling edge and issues each access as a pure read, a pure write or an idle cycle. It sweeps all eight mode codes, every palette index through three aliases of the palette window, and each nametable table through both nametable windows.

// File: rtl/pmm_pkg.sv
`timescale 1ns/1ps
package pmm_pkg;

    typedef enum logic [1:0] {
        RGN_CART = 2'd0,
        RGN_NT   = 2'd1,
        RGN_PAL  = 2'd2
    } region_e;

    // Folding modes for the four logical nametables
    typedef enum logic [2:0] {
        MIR_SPLIT_HI = 3'd0,
        MIR_SPLIT_LO = 3'd1,
        MIR_ONE_A    = 3'd2,
        MIR_ONE_B    = 3'd3,
        MIR_FOUR     = 3'd4
    } mirror_e;

endpackage

// File: rtl/pmm_decode.sv
`timescale 1ns/1ps
module pmm_decode
    import pmm_pkg::*;
#(
    parameter int AW       = 14,
    parameter int NT_OFF_W = 12,
    parameter int PAL_W    = 5
) (
    input  logic [AW-1:0]       addr_i,
    output region_e             region_o,
    output logic [NT_OFF_W-1:0] nt_off_o,
    output logic [PAL_W-1:0]    pal_raw_o
);
    localparam logic [AW-1:0] NT_BASE  = AW'(14'h2000);
    localparam logic [AW-1:0] PAL_BASE = AW'(14'h3F00);

    logic [AW-1:0] nt_full;
    logic [AW-1:0] pal_full;
    logic          unused_hi;

    always_comb begin
        nt_full  = addr_i - NT_BASE;
        pal_full = addr_i - PAL_BASE;
        if (addr_i < NT_BASE) begin
            region_o = RGN_CART;
        end else if (addr_i < PAL_BASE) begin
            region_o = RGN_NT;
        end else begin
            region_o = RGN_PAL;
        end
    end

    assign nt_off_o  = nt_full[NT_OFF_W-1:0];
    assign pal_raw_o = pal_full[PAL_W-1:0];
    assign unused_hi = ^{nt_full[AW-1:NT_OFF_W], pal_full[AW-1:PAL_W]};

endmodule

// File: rtl/pmm_nt_map.sv
`timescale 1ns/1ps
module pmm_nt_map
    import pmm_pkg::*;
#(
    parameter int NT_OFF_W = 12,
    parameter int RAM_AW   = 11,
    parameter int MODE_W   = 3
) (
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [NT_OFF_W-1:0] off_i,
    output logic [RAM_AW-1:0]   ram_addr_o
);
    localparam int BYTE_W = NT_OFF_W - 2;

    logic [1:0]          logical;
    logic [1:0]          phys;
    logic [BYTE_W-1:0]   byte_sel;
    logic [NT_OFF_W-1:0] full;
    logic                unused_top;

    always_comb begin
        logical  = off_i[NT_OFF_W-1 -: 2];
        byte_sel = off_i[BYTE_W-1:0];
        case (mode_i)
            MODE_W'(MIR_SPLIT_HI): phys = {1'b0, logical[1]};
            MODE_W'(MIR_SPLIT_LO): phys = {1'b0, logical[0]};
            MODE_W'(MIR_ONE_A):    phys = 2'd0;
            MODE_W'(MIR_ONE_B):    phys = 2'd1;
            default:               phys = logical;
        endcase
        full = {phys, byte_sel};
    end

    assign ram_addr_o = full[RAM_AW-1:0];
    assign unused_top = ^full[NT_OFF_W-1:RAM_AW];

endmodule

// File: rtl/pmm_nt_ram.sv
`timescale 1ns/1ps
module pmm_nt_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/pmm_pal_regs.sv
`timescale 1ns/1ps
module pmm_pal_regs #(
    parameter int IDX_W = 5,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] raw_idx_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [DW-1:0]    rdata_o
);
    localparam int               ENTRIES = 1 << IDX_W;
    localparam logic [IDX_W-1:0] HALF    = IDX_W'(ENTRIES / 2);

    typedef struct packed {
        logic [ENTRIES-1:0][DW-1:0] ent;
    } pal_state_t;

    pal_state_t       st_d, st_q;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = raw_idx_i;
        if (raw_idx_i[IDX_W-1] && (raw_idx_i[1:0] == 2'b00)) begin
            idx_d = raw_idx_i - HALF;
        end
        st_d = st_q;
        if (we_i) begin
            st_d.ent[idx_d] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o   = idx_d;
    assign rdata_o = st_q.ent[idx_d];

endmodule

// File: rtl/pic_mem_map.sv
`timescale 1ns/1ps
module pic_mem_map
    import pmm_pkg::*;
#(
    parameter int IN_AW   = 16,
    parameter int AW      = 14,
    parameter int DW      = 8,
    parameter int CART_AW = 13,
    parameter int NT_AW   = 11,
    parameter int PAL_W   = 5,
    parameter int MODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_AW-1:0]   addr_i,
    input  logic [DW-1:0]      wdata_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [MODE_W-1:0]  mirror_mode_i,
    input  logic [DW-1:0]      cart_rdata_i,
    output logic               cart_sel_o,
    output logic               cart_we_o,
    output logic [CART_AW-1:0] cart_addr_o,
    output logic [DW-1:0]      rdata_o,
    output logic [NT_AW-1:0]   nt_addr_o,
    output logic               nt_we_o,
    output logic [PAL_W-1:0]   pal_idx_o,
    output logic               pal_we_o
);
    localparam int NT_OFF_W = NT_AW + 1;

    logic [AW-1:0]       addr_m;
    logic                unused_addr;
    region_e             region;
    logic [NT_OFF_W-1:0] nt_off;
    logic [PAL_W-1:0]    pal_raw;
    logic [DW-1:0]       nt_rdata;
    logic [DW-1:0]       pal_rdata;
    logic [DW-1:0]       sel_rdata;

    // R1: only the low AW bits take part in decoding
    assign addr_m      = addr_i[AW-1:0];
    assign unused_addr = ^addr_i[IN_AW-1:AW];

    pmm_decode #(
        .AW       (AW),
        .NT_OFF_W (NT_OFF_W),
        .PAL_W    (PAL_W)
    ) u_decode (
        .addr_i    (addr_m),
        .region_o  (region),
        .nt_off_o  (nt_off),
        .pal_raw_o (pal_raw)
    );

    pmm_nt_map #(
        .NT_OFF_W (NT_OFF_W),
        .RAM_AW   (NT_AW),
        .MODE_W   (MODE_W)
    ) u_nt_map (
        .mode_i     (mirror_mode_i),
        .off_i      (nt_off),
        .ram_addr_o (nt_addr_o)
    );

    pmm_nt_ram #(
        .AW (NT_AW),
        .DW (DW)
    ) u_nt_ram (
        .clk     (clk),
        .we_i    (nt_we_o),
        .addr_i  (nt_addr_o),
        .wdata_i (wdata_i),
        .rdata_o (nt_rdata)
    );

    pmm_pal_regs #(
        .IDX_W (PAL_W),
        .DW    (DW)
    ) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (pal_we_o),
        .raw_idx_i (pal_raw),
        .wdata_i   (wdata_i),
        .idx_o     (pal_idx_o),
        .rdata_o   (pal_rdata)
    );

    always_comb begin
        cart_sel_o = (region == RGN_CART) && (rd_i || wr_i);
        cart_we_o  = (region == RGN_CART) && wr_i;
        nt_we_o    = (region == RGN_NT) && wr_i;
        pal_we_o   = (region == RGN_PAL) && wr_i;
        case (region)
            RGN_CART: sel_rdata = cart_rdata_i;
            RGN_NT:   sel_rdata = nt_rdata;
            default:  sel_rdata = pal_rdata;
        endcase
        rdata_o = rd_i ? sel_rdata : '0;
    end

    assign cart_addr_o = addr_m[CART_AW-1:0];

endmodule

// File: rtl/pmm_checker.sv
`timescale 1ns/1ps
module pmm_checker #(
    parameter int AW    = 14,
    parameter int DW    = 8,
    parameter int NT_AW = 11,
    parameter int PAL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    addr_i,
    input logic [DW-1:0]    wdata_i,
    input logic             rd_i,
    input logic             wr_i,
    input logic [2:0]       mirror_mode_i,
    input logic             cart_sel_o,
    input logic             cart_we_o,
    input logic [DW-1:0]    rdata_o,
    input logic [NT_AW-1:0] nt_addr_o,
    input logic             nt_we_o,
    input logic [PAL_W-1:0] pal_idx_o,
    input logic             pal_we_o
);
    logic in_nt;
    assign in_nt = addr_i[AW-1] && (addr_i[AW-1:AW-6] != 6'h3F);

    // R8
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cart_sel_o, nt_we_o, pal_we_o}));

    // R8
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0));

    // R2
    cart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cart_sel_o |-> !addr_i[AW-1]);

    // R2
    cart_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cart_we_o |-> (wr_i && cart_sel_o));

    // R3
    nt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nt_we_o |-> in_nt);

    // R6
    pal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we_o |-> (addr_i[AW-1:AW-6] == 6'h3F));

    // R6
    pal_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we_o |-> (!pal_idx_o[PAL_W-1] || (pal_idx_o[1:0] != 2'b00)));

    // R4
    mir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_we_o && (mirror_mode_i == 3'd2)) |-> !nt_addr_o[NT_AW-1]);

    // R5
    nt_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nt_we_o) && rd_i && !wr_i && in_nt && (nt_addr_o == $past(nt_addr_o)))
        |-> (rdata_o == $past(wdata_i)));

endmodule

bind pic_mem_map pmm_checker #(
    .AW    (AW),
    .DW    (DW),
    .NT_AW (NT_AW),
    .PAL_W (PAL_W)
) u_pmm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i[AW-1:0]),
    .wdata_i       (wdata_i),
    .rd_i          (rd_i),
    .wr_i          (wr_i),
    .mirror_mode_i (mirror_mode_i),
    .cart_sel_o    (cart_sel_o),
    .cart_we_o     (cart_we_o),
    .rdata_o       (rdata_o),
    .nt_addr_o     (nt_addr_o),
    .nt_we_o       (nt_we_o),
    .pal_idx_o     (pal_idx_o),
    .pal_we_o      (pal_we_o)
);

// File: tb/pic_mem_map_test.sv
`timescale 1ns/1ps
module pic_mem_map_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [2:0]  mirror_mode_i = '0;
    logic [7:0]  cart_rdata_i = '0;
    logic        cart_sel_o, cart_we_o, nt_we_o, pal_we_o;
    logic [12:0] cart_addr_o;
    logic [7:0]  rdata_o;
    logic [10:0] nt_addr_o;
    logic [4:0]  pal_idx_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [7:0] nt_model  [2048];
    logic [7:0] pal_model [32];

    always #5 clk = ~clk;

    pic_mem_map uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .rd_i(rd_i), .wr_i(wr_i), .mirror_mode_i(mirror_mode_i),
        .cart_rdata_i(cart_rdata_i), .cart_sel_o(cart_sel_o),
        .cart_we_o(cart_we_o), .cart_addr_o(cart_addr_o), .rdata_o(rdata_o),
        .nt_addr_o(nt_addr_o), .nt_we_o(nt_we_o), .pal_idx_o(pal_idx_o),
        .pal_we_o(pal_we_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int nt_exp(input int mode, input int a);
        int off = ((a & 16'h3FFF) - 16'h2000) & 16'hFFF;
        int lt  = off >> 10;
        int p;
        case (mode)
            0: p = lt >> 1;
            1: p = lt & 1;
            2: p = 0;
            3: p = 1;
            default: p = lt;
        endcase
        return ((p << 10) + (off & 16'h3FF)) & 16'h7FF;
    endfunction

    function automatic int pal_exp(input int a);
        int i = ((a & 16'h3FFF) - 16'h3F00) & 16'h1F;
        if (i >= 16 && (i & 3) == 0) i = i - 16;
        return i;
    endfunction

    task automatic drive(input int a, input bit rd, input bit wr, input int d);
        @(negedge clk);
        addr_i  = 16'(a);
        rd_i    = rd;
        wr_i    = wr;
        wdata_i = 8'(d);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        rd_i = 1'b0;
        wr_i = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: palette cleared by reset
        for (int i = 0; i < 32; i++) begin
            drive(16'h3F00 + i, 1, 0, 0);
            chk("R7 reset palette", rdata_o, 0);
            pal_model[i] = 8'h00;
        end

        // R2 / R1: cartridge region reads and writes
        for (int k = 0; k < 6; k++) begin
            int a;
            case (k)
                0: a = 16'h0000;
                1: a = 16'h1234;
                2: a = 16'h1FFF;
                3: a = 16'h9FFF;
                4: a = 16'h4ABC;
                default: a = 16'hC777;
            endcase
            cart_rdata_i = 8'(a ^ 16'h5A);
            drive(a, 1, 0, 0);
            chk("R2 cart sel on read", cart_sel_o, 1);
            chk("R1 R2 cart addr", cart_addr_o, a & 16'h1FFF);
            chk("R2 cart read data", rdata_o, (a ^ 16'h5A) & 16'hFF);
            chk("R2 cart we on read", cart_we_o, 0);
            drive(a, 0, 1, 8'h33);
            chk("R2 cart we on write", cart_we_o, 1);
            chk("R8 no nt/pal we in cart", {nt_we_o, pal_we_o}, 0);
        end
        idle();

        // R3 R4 R5: nametable folding in every mode code
        for (int m = 0; m < 8; m++) begin
            mirror_mode_i = 3'(m);
            for (int lt = 0; lt < 4; lt++) begin
                for (int k = 0; k < 4; k++) begin
                    int a = 16'h2000 + lt * 16'h400 + k * 16'h55;
                    int d = (m * 16 + lt * 4 + k + 7) & 8'hFF;
                    drive(a, 0, 1, d);
                    chk("R4 nt write addr", nt_addr_o, nt_exp(m, a));
                    chk("R8 nt we", nt_we_o, 1);
                    nt_model[nt_exp(m, a)] = 8'(d);
                end
            end
            for (int lt = 0; lt < 4; lt++) begin
                for (int k = 0; k < 4; k++) begin
                    int a = 16'h2000 + lt * 16'h400 + k * 16'h55;
                    int b = a + 16'h1000 + ((k & 1) ? 16'h8000 : 16'h4000);
                    drive(a, 1, 0, 0);
                    chk("R4 nt read addr", nt_addr_o, nt_exp(m, a));
                    chk("R5 nt read data", rdata_o, nt_model[nt_exp(m, a)]);
                    drive(b, 1, 0, 0);
                    chk("R3 R1 nt upper alias addr", nt_addr_o, nt_exp(m, a));
                    chk("R3 nt upper alias data", rdata_o, nt_model[nt_exp(m, a)]);
                    chk("R2 no cart sel in nt", cart_sel_o, 0);
                end
            end
            idle();
        end

        // R6 R7: palette writes with folding, then reads through aliases
        for (int i = 0; i < 32; i++) begin
            int d = (8'hA0 ^ (i * 5)) & 8'hFF;
            drive(16'h3F00 + i, 0, 1, d);
            chk("R6 pal write idx", pal_idx_o, pal_exp(16'h3F00 + i));
            chk("R8 pal we", pal_we_o, 1);
            pal_model[pal_exp(16'h3F00 + i)] = 8'(d);
        end
        idle();
        for (int i = 0; i < 32; i++) begin
            drive(16'h3F00 + i, 1, 0, 0);
            chk("R6 pal read idx", pal_idx_o, pal_exp(16'h3F00 + i));
            chk("R7 pal read data", rdata_o, pal_model[pal_exp(16'h3F00 + i)]);
            drive(16'h3F20 + i, 1, 0, 0);
            chk("R6 pal window alias", rdata_o, pal_model[pal_exp(16'h3F20 + i)]);
            drive(16'hFFE0 + i, 1, 0, 0);
            chk("R1 R6 pal high bits", rdata_o, pal_model[pal_exp(16'hFFE0 + i)]);
        end

        // R8: idle strobes leave data alone and read as zero
        mirror_mode_i = 3'd4;
        drive(16'h3F05, 0, 0, 8'hEE);
        chk("R8 rdata zero without rd", rdata_o, 0);
        chk("R8 pal we without wr", pal_we_o, 0);
        chk("R8 cart sel idle", cart_sel_o, 0);
        drive(16'h3F05, 1, 0, 0);
        chk("R8 pal unchanged", rdata_o, pal_model[5]);
        drive(16'h2000, 0, 0, 8'hEE);
        chk("R8 nt we without wr", nt_we_o, 0);
        drive(16'h2000, 1, 0, 0);
        chk("R8 nt unchanged", rdata_o, nt_model[nt_exp(4, 16'h2000)]);
        idle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule